// File: doc/BRIEF.md
# Erase-Zone Address Decoder with Boot Write Guard

This block takes an 18-bit word address and finds which of seven erase zones holds it. The zones differ in size: a boot zone of 8K words, two parameter zones of 4K words each, one main zone of 48K words and three main zones of 64K words each. A parameter chooses where the boot zone sits. In the bottom-boot layout it starts at word 0x00000. In the top-boot layout it ends at word 0x3FFFF, and the other zones are laid out in mirror order. For every address the block reports the zone index and the first word address of that zone.

The same block also decides whether a program or erase request may proceed. A request that targets the boot zone is refused unless the digital unlock flag is high. A refused boot request raises a protection-error flag, which status logic can use to set its error bit. While an erase is suspended, a program request aimed at the suspended zone is refused and raises a separate flag. When the power-enable input is low, the block reports idle and grants nothing.

The decode is combinational and passes through one register stage. Every output therefore follows its inputs by one clock.

Top module: `ezone_guard`

## Requirements
- R1: With BOOT_TOP=0, zone indices 0..6 start at words 0x00000, 0x02000, 0x03000, 0x04000, 0x10000, 0x20000 and 0x30000. The boot zone is index 0. `zone_idx` is the highest index whose start is not above the address, and `zone_base` is that start.
- R2: With BOOT_TOP=1, zone indices 0..6 start at words 0x00000, 0x10000, 0x20000, 0x30000, 0x3C000, 0x3D000 and 0x3E000. The boot zone is index 6 and ends at 0x3FFFF. Index 0 is always the lowest-addressed zone.
- R3: All outputs are registered. Each one reflects the inputs sampled at the previous rising clock edge. An active-low asynchronous reset clears every output to 0.
- R4: A program or erase request to the boot zone while `boot_unlock`=0 gives `grant`=0 and `prot_err`=1 in the next cycle.
- R5: A program or erase request to the boot zone while `boot_unlock`=1 gives `grant`=1 and `prot_err`=0.
- R6: A request to any non-boot zone that is not refused under R7 gives `grant`=1, whatever the value of `boot_unlock`. With no request, `grant`, `prot_err` and `susp_rej` stay 0.
- R7: While `erase_susp`=1, a program request whose zone index equals `susp_zone` gives `grant`=0 and `susp_rej`=1. A program request to any other zone is not affected by the suspension.
- R8: While `pwr_en`=0, the next cycle shows `valid`=0, `grant`=0, `prot_err`=0, `susp_rej`=0, `zone_idx`=0 and `zone_base`=0, whatever the request inputs. While `pwr_en`=1, `valid`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_en | input | 1 | 1 = operating, 0 = power down |
| addr | input | 18 | Word address to decode |
| req_prog | input | 1 | Program request |
| req_erase | input | 1 | Erase request |
| boot_unlock | input | 1 | Boot zone unlock flag |
| erase_susp | input | 1 | An erase is suspended |
| susp_zone | input | 3 | Index of the suspended zone |
| valid | output | 1 | Decoder active (not powered down) |
| zone_idx | output | 3 | Zone index of the address |
| zone_base | output | 18 | First word address of the zone |
| grant | output | 1 | Request allowed |
| prot_err | output | 1 | Boot request refused while locked |
| susp_rej | output | 1 | Program to the suspended zone refused |

## Verification
The bench builds two copies of the block side by side, one with BOOT_TOP=1 and one with BOOT_TOP=0, and drives both with the same stimulus. Because both layouts run together, one address can land in the boot zone of one copy and in a main zone of the other. This makes the lock, unlock and suspension rules observable in both mirror positions, including the edge words on either side of every parameter and boot boundary.

// File: rtl/ezone_pkg.sv
package ezone_pkg;
    localparam int NZONE   = 7;
    localparam int IDX_W   = $clog2(NZONE);
    localparam int NUNITS  = 64;   // address space split into 64 equal units
    localparam int UNIT_LG = 6;

    // zone size in units, listed from the lowest address upward
    function automatic int zone_units(input bit top, input int i);
        int k;
        k = top ? (NZONE - 1 - i) : i;
        case (k)
            0:       return 2;
            1, 2:    return 1;
            3:       return 12;
            default: return 16;
        endcase
    endfunction

    function automatic int zone_start(input bit top, input int i);
        int s;
        s = 0;
        for (int j = 0; j < i; j++) s += zone_units(top, j);
        return s;
    endfunction
endpackage

// File: rtl/ezone_map.sv
module ezone_map
    import ezone_pkg::*;
#(
    parameter int ADDR_W   = 18,
    parameter bit BOOT_TOP = 1'b0
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [IDX_W-1:0]  idx_o,
    output logic [ADDR_W-1:0] base_o
);
    localparam int UNIT_SH = ADDR_W - UNIT_LG;

    logic [UNIT_LG-1:0] unit_w;
    logic [NZONE-1:0]   at_or_above;
    logic [ADDR_W-1:0]  base_tab [NZONE];

    assign unit_w = addr_i[ADDR_W-1:UNIT_SH];

    for (genvar g = 0; g < NZONE; g++) begin : g_zone
        localparam int START_U = zone_start(BOOT_TOP, g);
        localparam logic [UNIT_LG-1:0] START_V = UNIT_LG'(START_U);
        assign at_or_above[g] = (unit_w >= START_V);
        assign base_tab[g]    = ADDR_W'(START_U) << UNIT_SH;
    end

    always_comb begin
        idx_o = '0;
        for (int i = 1; i < NZONE; i++) begin
            if (at_or_above[i]) idx_o = IDX_W'(i);
        end
        base_o = base_tab[idx_o];
    end
endmodule

// File: rtl/ezone_guard_logic.sv
module ezone_guard_logic
    import ezone_pkg::*;
#(
    parameter int BOOT_IDX = 0
) (
    input  logic [IDX_W-1:0] idx_i,
    input  logic             prog_i,
    input  logic             erase_i,
    input  logic             unlock_i,
    input  logic             susp_i,
    input  logic [IDX_W-1:0] susp_idx_i,
    output logic             grant_o,
    output logic             prot_o,
    output logic             srej_o
);
    logic any_req;
    logic in_boot;

    always_comb begin
        any_req = prog_i | erase_i;
        in_boot = (idx_i == IDX_W'(BOOT_IDX));
        prot_o  = any_req & in_boot & ~unlock_i;
        srej_o  = prog_i & susp_i & (idx_i == susp_idx_i);
        grant_o = any_req & ~prot_o & ~srej_o;
    end
endmodule

// File: rtl/ezone_guard.sv
module ezone_guard
    import ezone_pkg::*;
#(
    parameter int ADDR_W   = 18,
    parameter bit BOOT_TOP = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              req_prog,
    input  logic              req_erase,
    input  logic              boot_unlock,
    input  logic              erase_susp,
    input  logic [IDX_W-1:0]  susp_zone,
    output logic              valid,
    output logic [IDX_W-1:0]  zone_idx,
    output logic [ADDR_W-1:0] zone_base,
    output logic              grant,
    output logic              prot_err,
    output logic              susp_rej
);
    localparam int BOOT_IDX = BOOT_TOP ? NZONE - 1 : 0;

    typedef struct packed {
        logic              valid;
        logic [IDX_W-1:0]  idx;
        logic [ADDR_W-1:0] base;
        logic              grant;
        logic              prot;
        logic              srej;
    } out_t;

    out_t st_d, st_q;

    logic [IDX_W-1:0]  map_idx;
    logic [ADDR_W-1:0] map_base;
    logic              g_grant, g_prot, g_srej;

    ezone_map #(.ADDR_W(ADDR_W), .BOOT_TOP(BOOT_TOP)) u_map (
        .addr_i (addr),
        .idx_o  (map_idx),
        .base_o (map_base)
    );

    ezone_guard_logic #(.BOOT_IDX(BOOT_IDX)) u_guard (
        .idx_i      (map_idx),
        .prog_i     (req_prog),
        .erase_i    (req_erase),
        .unlock_i   (boot_unlock),
        .susp_i     (erase_susp),
        .susp_idx_i (susp_zone),
        .grant_o    (g_grant),
        .prot_o     (g_prot),
        .srej_o     (g_srej)
    );

    always_comb begin
        st_d = '0;
        if (pwr_en) begin
            st_d.valid = 1'b1;
            st_d.idx   = map_idx;
            st_d.base  = map_base;
            st_d.grant = g_grant;
            st_d.prot  = g_prot;
            st_d.srej  = g_srej;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid     = st_q.valid;
    assign zone_idx  = st_q.idx;
    assign zone_base = st_q.base;
    assign grant     = st_q.grant;
    assign prot_err  = st_q.prot;
    assign susp_rej  = st_q.srej;

    AST_PWRDN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_en |=> (!valid && !grant && !prot_err && !susp_rej)); // R8
    AST_PROT_ON_BOOT: assert property (@(posedge clk) disable iff (!rst_n)
        prot_err |-> (zone_idx == IDX_W'(BOOT_IDX) && !grant)); // R4
    AST_SREJ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_en && erase_susp && req_prog) |=> (susp_rej == (zone_idx == $past(susp_zone)))); // R7
    AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> $past(req_prog || req_erase)); // R6
    AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (zone_idx < IDX_W'(NZONE))); // R1
    AST_BASE_NOT_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (zone_base <= $past(addr))); // R2
endmodule

// File: tb/sim_ezone_guard.sv
`timescale 1ns/1ps
module sim_ezone_guard;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic        pwr_en = 1'b0, req_prog = 1'b0, req_erase = 1'b0;
    logic        boot_unlock = 1'b0, erase_susp = 1'b0;
    logic [17:0] addr = '0;
    logic [2:0]  susp_zone = '0;

    logic        v0, g0, p0, s0, v1, g1, p1, s1;
    logic [2:0]  i0, i1;
    logic [17:0] b0, b1;

    ezone_guard #(.ADDR_W(18), .BOOT_TOP(1'b1)) u0 (
        .clk, .rst_n, .pwr_en, .addr, .req_prog, .req_erase, .boot_unlock,
        .erase_susp, .susp_zone, .valid(v0), .zone_idx(i0), .zone_base(b0),
        .grant(g0), .prot_err(p0), .susp_rej(s0));
    ezone_guard #(.ADDR_W(18), .BOOT_TOP(1'b0)) u1 (
        .clk, .rst_n, .pwr_en, .addr, .req_prog, .req_erase, .boot_unlock,
        .erase_susp, .susp_zone, .valid(v1), .zone_idx(i1), .zone_base(b1),
        .grant(g1), .prot_err(p1), .susp_rej(s1));

    typedef struct packed {
        logic v; logic [2:0] i; logic [17:0] b; logic g; logic p; logic s;
    } res_t;
    typedef struct {
        int due; string tag; res_t top; res_t bot;
    } item_t;

    item_t sb[$];
    int cyc = 0, total = 0, bad = 0;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic res_t model(bit top, logic pw, logic [17:0] a, logic pg,
                                   logic er, logic un, logic su, logic [2:0] sz);
        int starts_bot [7] = '{'h00000, 'h02000, 'h03000, 'h04000, 'h10000, 'h20000, 'h30000};
        int starts_top [7] = '{'h00000, 'h10000, 'h20000, 'h30000, 'h3C000, 'h3D000, 'h3E000};
        res_t r;
        int k;
        r = '0;
        if (!pw) return r;
        k = 0;
        for (int j = 0; j < 7; j++)
            if ((top ? starts_top[j] : starts_bot[j]) <= int'(a)) k = j;
        r.v = 1'b1;
        r.i = 3'(k);
        r.b = 18'(top ? starts_top[k] : starts_bot[k]);
        r.p = (pg || er) && (k == (top ? 6 : 0)) && !un;
        r.s = pg && su && (3'(k) == sz);
        r.g = (pg || er) && !r.p && !r.s;
        return r;
    endfunction

    task automatic drive(string tag, logic pw, logic [17:0] a, logic pg, logic er,
                         logic un, logic su, logic [2:0] sz);
        item_t it;
        @(negedge clk);
        pwr_en = pw; addr = a; req_prog = pg; req_erase = er;
        boot_unlock = un; erase_susp = su; susp_zone = sz;
        it.due = cyc + 1;
        it.tag = tag;
        it.top = model(1'b1, pw, a, pg, er, un, su, sz);
        it.bot = model(1'b0, pw, a, pg, er, un, su, sz);
        sb.push_back(it);
    endtask

    always @(negedge clk) begin
        if (sb.size() > 0 && sb[0].due <= cyc) begin
            item_t it;
            res_t a0, a1;
            it = sb.pop_front();
            a0 = '{v0, i0, b0, g0, p0, s0};
            a1 = '{v1, i1, b1, g1, p1, s1};
            total += 2;
            if (a0 !== it.top) begin
                bad++;
                $display("FAIL %s top-boot: actual=%h expected=%h", it.tag, a0, it.top);
            end
            if (a1 !== it.bot) begin
                bad++;
                $display("FAIL %s bottom-boot: actual=%h expected=%h", it.tag, a1, it.bot);
            end
        end
    end

    task automatic finish_run;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        // R3: reset clears all outputs
        #20;
        total++;
        if ({v0, i0, b0, g0, p0, s0, v1, i1, b1, g1, p1, s1} !== '0) begin
            bad++;
            $display("FAIL R3 reset: actual=%h expected=0", {v0, i0, b0, g0, p0, s0, v1, i1, b1, g1, p1, s1});
        end
        @(negedge clk); rst_n = 1'b1;
        // R1 / R2: zone decode incl. edge words
        drive("R1", 1, 18'h00000, 0, 0, 0, 0, 0);
        drive("R1", 1, 18'h01FFF, 0, 0, 0, 0, 0);
        drive("R1", 1, 18'h02000, 0, 0, 0, 0, 0);
        drive("R1", 1, 18'h02FFF, 0, 0, 0, 0, 0);
        drive("R1", 1, 18'h03000, 0, 0, 0, 0, 0);
        drive("R1", 1, 18'h04000, 0, 0, 0, 0, 0);
        drive("R1", 1, 18'h0FFFF, 0, 0, 0, 0, 0);
        drive("R1", 1, 18'h10000, 0, 0, 0, 0, 0);
        drive("R2", 1, 18'h2ABCD, 0, 0, 0, 0, 0);
        drive("R2", 1, 18'h30000, 0, 0, 0, 0, 0);
        drive("R2", 1, 18'h3BFFF, 0, 0, 0, 0, 0);
        drive("R2", 1, 18'h3C000, 0, 0, 0, 0, 0);
        drive("R2", 1, 18'h3CFFF, 0, 0, 0, 0, 0);
        drive("R2", 1, 18'h3D000, 0, 0, 0, 0, 0);
        drive("R2", 1, 18'h3DFFF, 0, 0, 0, 0, 0);
        drive("R2", 1, 18'h3E000, 0, 0, 0, 0, 0);
        drive("R2", 1, 18'h3FFFF, 0, 0, 0, 0, 0);
        // R4: locked boot requests
        drive("R4", 1, 18'h3F000, 1, 0, 0, 0, 0);
        drive("R4", 1, 18'h00100, 0, 1, 0, 0, 0);
        drive("R4", 1, 18'h3E000, 0, 1, 0, 0, 0);
        drive("R4", 1, 18'h01FFF, 1, 0, 0, 0, 0);
        // R5: unlocked boot requests
        drive("R5", 1, 18'h3FFFF, 1, 0, 1, 0, 0);
        drive("R5", 1, 18'h00000, 0, 1, 1, 0, 0);
        // R6: non-boot requests and no-request cases
        drive("R6", 1, 18'h12345, 1, 0, 0, 0, 0);
        drive("R6", 1, 18'h3C800, 0, 1, 1, 0, 0);
        drive("R6", 1, 18'h3F000, 0, 0, 0, 0, 0);
        // R7: suspension
        drive("R7", 1, 18'h21000, 1, 0, 0, 1, 3'd2);
        drive("R7", 1, 18'h21000, 1, 0, 0, 1, 3'd5);
        drive("R7", 1, 18'h3D800, 1, 0, 0, 1, 3'd5);
        drive("R7", 1, 18'h02800, 1, 0, 0, 1, 3'd1);
        drive("R7", 1, 18'h02800, 0, 1, 0, 1, 3'd1);
        drive("R7", 1, 18'h3E100, 1, 0, 1, 1, 3'd6);
        // R8: power down
        drive("R8", 0, 18'h3F000, 1, 0, 0, 0, 0);
        drive("R8", 0, 18'h10000, 0, 1, 1, 1, 3'd4);
        drive("R8", 1, 18'h10000, 0, 1, 1, 0, 0);
        drive("R3", 1, 18'h0ABCD, 0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule